// File: doc/BRIEF.md
# Slew-Rate Calibration Sequencer

This block runs the high-speed transmitter slew-rate trim for two USB 2.0 PHY ports with no processor involved. A single start pulse begins the run. Port 0 is trimmed first and port 1 second. For each port the block raises the port's calibration-enable bit, waits one millisecond, and then sets up the frequency meter. The meter setup is: free-run clock on, monitor clock select set to the port index, window length 0x400, meter on.

The block then reads the meter result up to ten times, one millisecond apart, and stops at the first non-zero value. It shuts the meter path down in the reverse of the setup order and waits another millisecond. It then writes a 3-bit trim code into the port's control register. When a result was found, the code comes from a rounded integer division of that result. When the meter never answered, the code is 4.

The millisecond comes from an internal prescaler of `TICK_CYC` system clocks. The division runs on a multi-cycle restoring divider. Control registers are updated by read-modify-write through a one-port select, read-data and write-strobe interface, so every bit outside the trim field and the calibration enable keeps its value. A one-cycle done pulse marks the end of port 1, and both codes are then held on dedicated outputs.

Top module: `srcal_seq`

## Requirements
- R1: After reset, the following outputs are all low or zero: `frck_en_o`, `meter_en_o`, `ctrl_we_o`, `done_o`, `mon_sel_o`, `win_len_o`, `code0_o` and `code1_o`.
- R2: For each port, the first control write sets bit 23 (calibration enable). `frck_en_o` rises exactly `TICK_CYC`+1 cycles after that write is presented. `meter_en_o` rises only once `frck_en_o` is high and `win_len_o` equals 0x400.
- R3: The meter result is first sampled one cycle after `meter_en_o` rises, then again every `TICK_CYC`+1 cycles, for at most 10 samples, stopping at the first non-zero one. `meter_en_o` therefore stays high for j·(`TICK_CYC`+1)+2 cycles when sample j is the first non-zero one (j counted from 0), and for 9·`TICK_CYC`+11 cycles on timeout.
- R4: Teardown runs in this order: `meter_en_o` falls while `frck_en_o` is still high, `frck_en_o` falls, then the control write clearing bit 23 follows. The code write comes at least `TICK_CYC`+1 cycles after the clearing write.
- R5: For a non-zero result R, the code is ((573440 / R) + 500) / 1000 in integer arithmetic, keeping the low 3 bits.
- R6: If all 10 samples read zero, the code is 4.
- R7: Each port gets exactly three control writes: set bit 23, clear bit 23, then write the code into bits [18:16]. All bits other than 23 and [18:16] keep the value read back from the register.
- R8: Port 0 is handled before port 1. `ctrl_sel_o` selects the port being written (0 or 1), and `mon_sel_o` equals that port index while the meter is on.
- R9: `done_o` pulses high for one cycle after the second port's code write. While it is high, `code0_o` and `code1_o` hold the codes written to ports 0 and 1.
- R10: A start pulse while a run is in progress is ignored: the run still makes exactly six control writes and a single done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse to begin a two-port run |
| meter_result_i | input | 32 | Frequency-meter count, zero until measurement completes |
| ctrl_rd_i | input | 32 | Read data of the control register chosen by ctrl_sel_o |
| ctrl_sel_o | output | 1 | Port whose control register is read and written |
| ctrl_we_o | output | 1 | Write strobe for the selected control register |
| ctrl_wdata_o | output | 32 | Write data for the selected control register |
| frck_en_o | output | 1 | Free-run clock enable |
| mon_sel_o | output | 2 | Meter monitor clock select |
| win_len_o | output | 24 | Meter window length |
| meter_en_o | output | 1 | Frequency-meter enable |
| done_o | output | 1 | One-cycle pulse when both ports are trimmed |
| code0_o | output | 3 | Trim code for port 0 |
| code1_o | output | 3 | Trim code for port 1 |

## Verification
A sequencer stuck in the wrong state, or one that skipped a wait, shows up on the enable outputs within the same millisecond. It shows as a wrong gap between the enable write and the free-run clock rise, or a wrong meter-on duration. A wrong poll count or poll spacing changes the meter-on time by whole multiples of `TICK_CYC`+1 cycles. A divider or rounding fault leaves the control outputs correct but changes the code seen in the written field and on the code outputs at the done pulse. A slip in the port index shows as the wrong `ctrl_sel_o` on a write or a wrong `mon_sel_o` at meter enable.

// File: rtl/srcal_pkg.sv
package srcal_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CAL_ON,
    ST_WAIT_ON,
    ST_FRCK_ON,
    ST_SEL,
    ST_WIN,
    ST_MEN_ON,
    ST_READ,
    ST_POLL_WAIT,
    ST_MEN_OFF,
    ST_FRCK_OFF,
    ST_CAL_OFF,
    ST_WAIT_OFF,
    ST_DIV,
    ST_CODE_WR,
    ST_NEXT
  } seq_state_e;
endpackage

// File: rtl/srcal_tick.sv
module srcal_tick #(
  parameter int TICK_CYC = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  // counter parks at zero when idle so every wait is a full period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/srcal_div.sv
module srcal_div #(
  parameter int NW = 20,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          ready_o,
  output logic [NW-1:0] quo_o
);
  localparam int CW = $clog2(NW + 1);

  logic [DW:0]   rem_q, rem_sh;
  logic [DW+1:0] diff;
  logic [NW-1:0] quo_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, ge;

  always_comb begin
    rem_sh = {rem_q[DW-1:0], quo_q[NW-1]};
    diff   = {1'b0, rem_sh} - {2'b00, den_i};
    ge     = !diff[DW+1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      quo_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      ready_o <= 1'b0;
    end else begin
      ready_o <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        quo_q  <= num_i;
        cnt_q  <= CW'(NW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? diff[DW:0] : rem_sh;
        quo_q <= {quo_q[NW-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q  <= 1'b0;
          ready_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = quo_q;
endmodule

// File: rtl/srcal_seq.sv
module srcal_seq
  import srcal_pkg::*;
#(
  parameter int              TICK_CYC = 100000,
  parameter int              RW       = 32,
  parameter int              SEL_W    = 2,
  parameter int              WIN_W    = 24,
  parameter logic [WIN_W-1:0] WIN_LEN = 'h400,
  parameter int              POLL_MAX = 10,
  parameter int              CAL_BIT  = 23,
  parameter int              CODE_LSB = 16,
  parameter int              CODE_W   = 3,
  parameter int              CODE_DEF = 4,
  parameter int              REF_MHZ  = 20,
  parameter int              SR_COEF  = 28,
  parameter int              SCALE    = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RW-1:0]     meter_result_i,
  input  logic [RW-1:0]     ctrl_rd_i,
  output logic              ctrl_sel_o,
  output logic              ctrl_we_o,
  output logic [RW-1:0]     ctrl_wdata_o,
  output logic              frck_en_o,
  output logic [SEL_W-1:0]  mon_sel_o,
  output logic [WIN_W-1:0]  win_len_o,
  output logic              meter_en_o,
  output logic              done_o,
  output logic [CODE_W-1:0] code0_o,
  output logic [CODE_W-1:0] code1_o
);
  localparam int NUM   = 1024 * REF_MHZ * SR_COEF;
  localparam int NW    = $clog2(NUM + 1);
  localparam int HALF  = SCALE / 2;
  localparam int PCW   = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam logic [RW-1:0] CAL_MASK   = RW'(1) << CAL_BIT;
  localparam logic [RW-1:0] FIELD_MASK = ((RW'(1) << CODE_W) - RW'(1)) << CODE_LSB;

  seq_state_e        state_q;
  logic              port_q;
  logic [PCW-1:0]    poll_q;
  logic [RW-1:0]     res_q;
  logic [CODE_W-1:0] code_q;
  logic              tick, tick_en, div_start, div_ready;
  logic [NW-1:0]     quo;
  logic [CODE_W-1:0] code_calc;

  assign tick_en = (state_q == ST_WAIT_ON) || (state_q == ST_POLL_WAIT) ||
                   (state_q == ST_WAIT_OFF);
  assign div_start = (state_q == ST_WAIT_OFF) && tick && (res_q != '0);
  assign code_calc = CODE_W'((NW'(quo) + NW'(HALF)) / NW'(SCALE));
  assign ctrl_sel_o = port_q;

  srcal_tick #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tick_en),
    .tick_o(tick)
  );

  srcal_div #(.NW(NW), .DW(RW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start),
    .num_i  (NW'(NUM)),
    .den_i  (res_q),
    .ready_o(div_ready),
    .quo_o  (quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      port_q       <= 1'b0;
      poll_q       <= '0;
      res_q        <= '0;
      code_q       <= '0;
      ctrl_we_o    <= 1'b0;
      ctrl_wdata_o <= '0;
      frck_en_o    <= 1'b0;
      mon_sel_o    <= '0;
      win_len_o    <= '0;
      meter_en_o   <= 1'b0;
      done_o       <= 1'b0;
      code0_o      <= '0;
      code1_o      <= '0;
    end else begin
      ctrl_we_o <= 1'b0;
      done_o    <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          port_q  <= 1'b0;
          state_q <= ST_CAL_ON;
        end
        ST_CAL_ON: begin
          ctrl_we_o    <= 1'b1;
          ctrl_wdata_o <= ctrl_rd_i | CAL_MASK;
          state_q      <= ST_WAIT_ON;
        end
        ST_WAIT_ON: if (tick) state_q <= ST_FRCK_ON;
        ST_FRCK_ON: begin
          frck_en_o <= 1'b1;
          state_q   <= ST_SEL;
        end
        ST_SEL: begin
          mon_sel_o <= SEL_W'(port_q);
          state_q   <= ST_WIN;
        end
        ST_WIN: begin
          win_len_o <= WIN_LEN;
          state_q   <= ST_MEN_ON;
        end
        ST_MEN_ON: begin
          meter_en_o <= 1'b1;
          poll_q     <= '0;
          state_q    <= ST_READ;
        end
        ST_READ: begin
          if (meter_result_i != '0) begin
            res_q   <= meter_result_i;
            state_q <= ST_MEN_OFF;
          end else if (poll_q == PCW'(POLL_MAX - 1)) begin
            res_q   <= '0;
            state_q <= ST_MEN_OFF;
          end else begin
            poll_q  <= poll_q + 1'b1;
            state_q <= ST_POLL_WAIT;
          end
        end
        ST_POLL_WAIT: if (tick) state_q <= ST_READ;
        ST_MEN_OFF: begin
          meter_en_o <= 1'b0;
          state_q    <= ST_FRCK_OFF;
        end
        ST_FRCK_OFF: begin
          frck_en_o <= 1'b0;
          state_q   <= ST_CAL_OFF;
        end
        ST_CAL_OFF: begin
          ctrl_we_o    <= 1'b1;
          ctrl_wdata_o <= ctrl_rd_i & ~CAL_MASK;
          state_q      <= ST_WAIT_OFF;
        end
        ST_WAIT_OFF: if (tick) state_q <= ST_DIV;
        ST_DIV: begin
          if (res_q == '0) begin
            code_q  <= CODE_W'(CODE_DEF);
            state_q <= ST_CODE_WR;
          end else if (div_ready) begin
            code_q  <= code_calc;
            state_q <= ST_CODE_WR;
          end
        end
        ST_CODE_WR: begin
          ctrl_we_o    <= 1'b1;
          ctrl_wdata_o <= (ctrl_rd_i & ~FIELD_MASK) | (RW'(code_q) << CODE_LSB);
          if (port_q) code1_o <= code_q;
          else        code0_o <= code_q;
          state_q <= ST_NEXT;
        end
        ST_NEXT: begin
          if (port_q) begin
            done_o  <= 1'b1;
            port_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            port_q  <= 1'b1;
            state_q <= ST_CAL_ON;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srcal_seq_chk.sv
module srcal_seq_chk #(
  parameter int               RW       = 32,
  parameter int               SEL_W    = 2,
  parameter int               WIN_W    = 24,
  parameter logic [WIN_W-1:0] WIN_LEN  = 'h400,
  parameter int               CAL_BIT  = 23,
  parameter int               CODE_LSB = 16,
  parameter int               CODE_W   = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [RW-1:0]    ctrl_rd_i,
  input logic             ctrl_sel_o,
  input logic             ctrl_we_o,
  input logic [RW-1:0]    ctrl_wdata_o,
  input logic             frck_en_o,
  input logic [SEL_W-1:0] mon_sel_o,
  input logic [WIN_W-1:0] win_len_o,
  input logic             meter_en_o,
  input logic             done_o
);
  localparam logic [RW-1:0] KEEP =
    ~((RW'(1) << CAL_BIT) | (((RW'(1) << CODE_W) - RW'(1)) << CODE_LSB));

  // R2
  men_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(meter_en_o) |-> frck_en_o && (win_len_o == WIN_LEN));

  // R8
  mon_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(meter_en_o) |-> (mon_sel_o == SEL_W'(ctrl_sel_o)));

  // R4
  men_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(meter_en_o) |-> frck_en_o);

  // R4
  frck_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frck_en_o) |-> !meter_en_o);

  // R7
  keep_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_o |-> ((ctrl_wdata_o & KEEP) == (ctrl_rd_i & KEEP)));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !frck_en_o && !meter_en_o && !ctrl_we_o);
endmodule

bind srcal_seq srcal_seq_chk #(
  .RW(RW), .SEL_W(SEL_W), .WIN_W(WIN_W), .WIN_LEN(WIN_LEN),
  .CAL_BIT(CAL_BIT), .CODE_LSB(CODE_LSB), .CODE_W(CODE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_rd_i   (ctrl_rd_i),
  .ctrl_sel_o  (ctrl_sel_o),
  .ctrl_we_o   (ctrl_we_o),
  .ctrl_wdata_o(ctrl_wdata_o),
  .frck_en_o   (frck_en_o),
  .mon_sel_o   (mon_sel_o),
  .win_len_o   (win_len_o),
  .meter_en_o  (meter_en_o),
  .done_o      (done_o)
);

// File: tb/srcal_seq_bench.sv
`timescale 1ns/1ps
module srcal_seq_bench;
  localparam int T = 20;
  localparam int WIN = 'h400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] meter_res = '0;
  logic [31:0] ctrl_rd, ctrl_wdata;
  logic        ctrl_sel, ctrl_we, frck, men, done;
  logic [1:0]  mon_sel;
  logic [23:0] win;
  logic [2:0]  code0, code1;

  always #2.5 clk = ~clk;

  srcal_seq #(.TICK_CYC(T)) u_srcal_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .meter_result_i(meter_res),
    .ctrl_rd_i(ctrl_rd), .ctrl_sel_o(ctrl_sel), .ctrl_we_o(ctrl_we),
    .ctrl_wdata_o(ctrl_wdata), .frck_en_o(frck), .mon_sel_o(mon_sel),
    .win_len_o(win), .meter_en_o(men), .done_o(done),
    .code0_o(code0), .code1_o(code1)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // control register model
  logic [31:0] creg [2];
  logic        ld = 1'b0;
  logic [31:0] ld0 = '0, ld1 = '0;
  always @(posedge clk) begin
    if (ld) begin creg[0] <= ld0; creg[1] <= ld1; end
    else if (ctrl_we) creg[ctrl_sel] <= ctrl_wdata;
  end
  assign ctrl_rd = creg[ctrl_sel];

  // meter model: result appears m_dly cycles after enable
  logic [31:0] m_res [2];
  int          m_dly [2];
  int          mcnt = 0;
  always @(negedge clk) begin
    if (men) begin
      meter_res <= (mcnt >= m_dly[mon_sel[0]]) ? m_res[mon_sel[0]] : 32'd0;
      mcnt <= mcnt + 1;
    end else begin
      mcnt <= 0;
      meter_res <= '0;
    end
  end

  // event monitor
  int cyc = 0, t_calon = 0, t_caloff = 0, t_men = 0, wr_cnt = 0;
  int dur [2];
  bit p_men = 0, p_frck = 0;
  always @(negedge clk) begin
    int idx, prt;
    cyc++;
    if (rst_n) begin
      if (ctrl_we) begin
        idx = wr_cnt % 3;
        prt = wr_cnt / 3;
        chk(prt < 2, "R10 write count", wr_cnt, 5);
        chk(ctrl_sel == prt[0], "R8 write port", ctrl_sel, prt);
        if (idx == 0) begin
          chk(ctrl_wdata[23], "R2 cal enable set", ctrl_wdata[23], 1);
          t_calon = cyc;
        end else if (idx == 1) begin
          chk(!ctrl_wdata[23], "R7 cal enable clear", ctrl_wdata[23], 0);
          chk(!frck && !men, "R4 clear after meter/clock off", {frck, men}, 0);
          t_caloff = cyc;
        end else begin
          chk(cyc - t_caloff >= T + 1, "R4 wait before code", cyc - t_caloff, T + 1);
        end
        wr_cnt++;
      end
      if (frck && !p_frck) chk(cyc - t_calon == T + 1, "R2 1ms gap", cyc - t_calon, T + 1);
      if (!frck && p_frck) chk(!men, "R4 meter off first", men, 0);
      if (men && !p_men) begin
        chk(frck, "R2 clock before meter", frck, 1);
        chk(win == WIN, "R2 window", win, WIN);
        chk(mon_sel == 2'(wr_cnt / 3), "R8 mon sel", mon_sel, wr_cnt / 3);
        t_men = cyc;
      end
      if (!men && p_men) begin
        if (wr_cnt / 3 < 2) dur[wr_cnt / 3] = cyc - t_men;
        chk(frck, "R4 clock held at meter off", frck, 1);
      end
    end
    p_men  = men;
    p_frck = frck;
  end

  function automatic bit found(input logic [31:0] r, input int d);
    int j = (d + T) / (T + 1);
    return (r != 0) && (j <= 9);
  endfunction

  function automatic int exp_code(input logic [31:0] r, input int d);
    longint q;
    if (!found(r, d)) return 4;
    q = (longint'(573440) / longint'({32'd0, r}) + 500) / 1000;
    return int'(q % 8);
  endfunction

  function automatic int exp_dur(input logic [31:0] r, input int d);
    int j = (d + T) / (T + 1);
    if (!found(r, d)) return 9 * T + 11;
    return j * (T + 1) + 2;
  endfunction

  task automatic run(input logic [31:0] r0, input int d0, input logic [31:0] r1,
                     input int d1, input bit stray);
    logic [31:0] i0, i1, e0, e1;
    int guard;
    i0 = $urandom; i1 = $urandom;
    @(negedge clk); ld0 = i0; ld1 = i1; ld = 1'b1;
    @(negedge clk); ld = 1'b0;
    m_res[0] = r0; m_dly[0] = d0; m_res[1] = r1; m_dly[1] = d1;
    wr_cnt = 0; dur[0] = -1; dur[1] = -1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    if (stray) begin
      repeat (2 * T) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    chk(done, "R9 done seen", done, 1);
    chk(code0 == 3'(exp_code(r0, d0)), (found(r0, d0) ? "R5 code0" : "R6 code0 default"),
        code0, exp_code(r0, d0));
    chk(code1 == 3'(exp_code(r1, d1)), (found(r1, d1) ? "R5 code1" : "R6 code1 default"),
        code1, exp_code(r1, d1));
    e0 = (i0 & ~32'h0087_0000) | (32'(exp_code(r0, d0)) << 16);
    e1 = (i1 & ~32'h0087_0000) | (32'(exp_code(r1, d1)) << 16);
    chk(creg[0] == e0, "R7 port0 register", creg[0], e0);
    chk(creg[1] == e1, "R7 port1 register", creg[1], e1);
    chk(dur[0] == exp_dur(r0, d0), "R3 port0 poll time", dur[0], exp_dur(r0, d0));
    chk(dur[1] == exp_dur(r1, d1), "R3 port1 poll time", dur[1], exp_dur(r1, d1));
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    chk(wr_cnt == 6, "R10 six writes", wr_cnt, 6);
    if (stray) begin
      repeat (3 * T) @(negedge clk);
      chk(wr_cnt == 6 && !frck, "R10 no restart", wr_cnt, 6);
    end
  endtask

  initial begin
    void'($urandom(32'd5150));
    #200_000ps;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!frck && !men && !ctrl_we && !done, "R1 reset controls", {frck, men, ctrl_we, done}, 0);
    chk(mon_sel == 0 && win == 0, "R1 reset meter setup", win, 0);
    chk(code0 == 0 && code1 == 0, "R1 reset codes", {code0, code1}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(32'd1024, 0, 32'd1024, 0, 1'b0);
    run(32'd0, 0, 32'd700, 2 * (T + 1), 1'b1);
    run(32'd1, 5, 32'hFFFF_FFFF, T + 2, 1'b0);
    run(32'd300, 12 * (T + 1), 32'd90, 9 * (T + 1), 1'b0);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] ra, rb;
      ra = ($urandom_range(0, 7) == 0) ? 32'd0 : 32'($urandom_range(1, 4000));
      rb = ($urandom_range(0, 7) == 0) ? 32'd0 : 32'($urandom_range(1, 4000));
      run(ra, $urandom_range(0, 11 * (T + 1)), rb, $urandom_range(0, 11 * (T + 1)),
          bit'(k % 2));
    end
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule